// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 14-bit virtual address into a physical address by reading a two-level page table from memory. A requester presents the virtual address together with an access kind (read or write). The walker then reads a directory entry from the directory frame named by a base input, and reads the leaf entry from the sub-table frame that the directory entry names. It checks the entry flags and returns a physical address or a fault code with a one-cycle done strobe.

Memory is reached through a single-word request interface. The walker holds a request with a stable address until the memory acknowledges it, and read data is taken in the acknowledge cycle. A directory entry marked invalid ends the walk after one read, so unused sub-tables never have to exist in memory. A successful walk writes the leaf entry back only when its accessed or dirty flag has to change. Only one walk runs at a time, and a busy output tells the requester when a new walk can be accepted.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, busy, done and mem_req are all 0.
- R2: The first memory access of a walk is a read of the directory entry at byte address {dir_base_pfn, vaddr[13:10], 2'b00}.
- R3: A directory entry with bit 0 clear ends the walk with resp_code 1 after exactly one memory read and no write.
- R4: For a valid directory entry, the second access is a read of the leaf entry at byte address {dir_entry[15:8], vaddr[9:6], 2'b00}.
- R5: A leaf entry with bit 0 (valid) clear gives resp_code 2, and nothing is written back.
- R6: A leaf entry with valid set and bit 1 (present) clear gives resp_code 3, and nothing is written back.
- R7: A write access to a valid, present leaf entry with bit 2 (writable) clear gives resp_code 4, and nothing is written back.
- R8: A successful walk gives resp_code 0 and pa = {leaf[15:8], vaddr[5:0]}. Every faulting walk gives pa = 0.
- R9: A successful walk sets bit 3 (accessed) of the leaf entry. A successful write access also sets bit 4 (dirty). The updated entry is written to the leaf address.
- R10: When the accessed flag, and for a write also the dirty flag, are already set, the walk performs no write-back.
- R11: busy is 1 from the cycle after a request is accepted through the done cycle. req_valid has no effect while busy is 1.
- R12: done is a single-cycle pulse. mem_req stays asserted, with mem_addr and mem_we unchanged, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when busy is 0) |
| req_vaddr | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| dir_base_pfn | input | 8 | Frame number of the page directory |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access to memory |
| mem_addr | output | 14 | Byte address of the 32-bit entry |
| mem_wdata | output | 32 | Write-back entry value |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result valid strobe |
| resp_code | output | 3 | 0 ok, 1 directory invalid, 2 entry invalid, 3 not present, 4 protection |
| pa | output | 14 | Physical address (0 on fault) |

## Verification
On every cycle the assertions check the memory handshake: the request stays stable until acknowledged, no request is made while idle, and every write-back carries the accessed flag. They also check that done is a single-cycle pulse inside a busy period and that a fault always returns a zero address. The bench scenarios are the only check of the translation and fault classification. These scenarios cover the directory and leaf addresses, the priority of the fault kinds, the exact memory contents after a flag update, the absence of redundant write-backs, and that a request made during a walk is ignored. They run under several memory latencies.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_LEAF,
    ST_WB,
    ST_FIN
  } walk_state_e;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_DIR_INV = 3'd1,
    RC_PTE_INV = 3'd2,
    RC_ABSENT  = 3'd3,
    RC_PROT    = 3'd4
  } walk_rc_e;

  localparam int unsigned ENTRY_W   = 32;
  localparam int unsigned B_VALID   = 0;
  localparam int unsigned B_PRES    = 1;
  localparam int unsigned B_WRITE   = 2;
  localparam int unsigned B_ACC     = 3;
  localparam int unsigned B_DIRTY   = 4;
  localparam int unsigned FRAME_LSB = 8;
endpackage

// File: rtl/pgwalk_eval.sv
module pgwalk_eval
  import pgwalk_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  output walk_rc_e           rc,
  output logic [ENTRY_W-1:0] upd,
  output logic               need_wb
);
  always_comb begin
    upd = entry;
    upd[B_ACC] = 1'b1;
    if (is_write) upd[B_DIRTY] = 1'b1;
    if (!entry[B_VALID])                    rc = RC_PTE_INV;
    else if (!entry[B_PRES])                rc = RC_ABSENT;
    else if (is_write && !entry[B_WRITE])   rc = RC_PROT;
    else                                    rc = RC_OK;
    need_wb = (upd != entry);
  end
endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
  import pgwalk_pkg::*;
#(
  parameter int unsigned PFN_W = 8,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned MA_W = PFN_W + IDX_W + 2
) (
  input  walk_state_e      st,
  input  logic [PFN_W-1:0] base_pfn,
  input  logic [PFN_W-1:0] tbl_pfn,
  input  logic [IDX_W-1:0] pd_idx,
  input  logic [IDX_W-1:0] pt_idx,
  output logic [MA_W-1:0]  addr
);
  always_comb begin
    if (st == ST_DIR) addr = {base_pfn, pd_idx, 2'b00};
    else              addr = {tbl_pfn, pt_idx, 2'b00};
  end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_ack,
  input  logic        dir_valid,
  input  logic        leaf_ok,
  input  logic        leaf_wb,
  output walk_state_e st
);
  walk_state_e st_nxt;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (req_valid) st_nxt = ST_DIR;
      ST_DIR:  if (mem_ack) st_nxt = dir_valid ? ST_LEAF : ST_FIN;
      ST_LEAF: if (mem_ack) st_nxt = (leaf_ok && leaf_wb) ? ST_WB : ST_FIN;
      ST_WB:   if (mem_ack) st_nxt = ST_FIN;
      ST_FIN:  st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned PFN_W = 8,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned OFF_W = IDX_W + 2,
  localparam int unsigned VA_W  = 2 * IDX_W + OFF_W,
  localparam int unsigned MA_W  = PFN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic [PFN_W-1:0]   dir_base_pfn,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MA_W-1:0]    mem_addr,
  output logic [ENTRY_W-1:0] mem_wdata,
  input  logic               mem_ack,
  input  logic [ENTRY_W-1:0] mem_rdata,
  output logic               done,
  output logic [2:0]         resp_code,
  output logic [MA_W-1:0]    pa
);
  walk_state_e        st;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [PFN_W-1:0]   tbl_q;
  logic [ENTRY_W-1:0] wb_q;
  walk_rc_e           rc_q;
  logic [MA_W-1:0]    pa_q;

  walk_rc_e           leaf_rc;
  logic [ENTRY_W-1:0] leaf_upd;
  logic               leaf_wb;
  logic               leaf_ok;
  logic               dir_valid;
  logic               accept, dir_ack, leaf_ack;

  assign accept    = (st == ST_IDLE) && req_valid;
  assign dir_ack   = (st == ST_DIR) && mem_ack;
  assign leaf_ack  = (st == ST_LEAF) && mem_ack;
  assign dir_valid = mem_rdata[B_VALID];
  assign leaf_ok   = (leaf_rc == RC_OK);

  pgwalk_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_ack(mem_ack),
    .dir_valid(dir_valid), .leaf_ok(leaf_ok), .leaf_wb(leaf_wb), .st(st)
  );

  pgwalk_eval i_eval (
    .entry(mem_rdata), .is_write(wr_q), .rc(leaf_rc), .upd(leaf_upd), .need_wb(leaf_wb)
  );

  pgwalk_addr #(.PFN_W(PFN_W), .IDX_W(IDX_W)) i_addr (
    .st(st), .base_pfn(dir_base_pfn), .tbl_pfn(tbl_q),
    .pd_idx(va_q[VA_W-1 -: IDX_W]), .pt_idx(va_q[OFF_W +: IDX_W]), .addr(mem_addr)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q <= '0;
      wr_q <= 1'b0;
    end else if (accept) begin
      va_q <= req_vaddr;
      wr_q <= req_write;
    end
  end

  // sub-table frame from the directory entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tbl_q <= '0;
    else if (dir_ack) tbl_q <= mem_rdata[FRAME_LSB +: PFN_W];
  end

  // write-back value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wb_q <= '0;
    else if (leaf_ack) wb_q <= leaf_upd;
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= RC_OK;
      pa_q <= '0;
    end else if (accept) begin
      rc_q <= RC_OK;
      pa_q <= '0;
    end else if (dir_ack && !dir_valid) begin
      rc_q <= RC_DIR_INV;
    end else if (leaf_ack) begin
      rc_q <= leaf_rc;
      pa_q <= leaf_ok ? {mem_rdata[FRAME_LSB +: PFN_W], va_q[OFF_W-1:0]} : '0;
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_DIR) || (st == ST_LEAF) || (st == ST_WB);
  assign mem_we    = (st == ST_WB);
  assign mem_wdata = wb_q;
  assign done      = (st == ST_FIN);
  assign resp_code = rc_q;
  assign pa        = pa_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned MA_W = 14,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [MA_W-1:0] mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic [2:0]      resp_code,
  input logic [MA_W-1:0] pa
);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r11_done_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r9_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[3]);
  a_r8_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp_code != 3'd0) |-> (pa == '0));
endmodule

bind pgwalk_top pgwalk_chk #(.MA_W(MA_W), .DW(pgwalk_pkg::ENTRY_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .resp_code(resp_code), .pa(pa)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  dir_base_pfn = 8'h20;
  logic        busy, mem_req, mem_we, done;
  logic [13:0] mem_addr, pa;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  resp_code;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  logic [31:0] mem [int];

  typedef struct {
    logic [2:0]  code;
    logic [13:0] pa;
    int          nrd;
    int          nwr;
    logic [13:0] a0;
    logic [13:0] a1;
    logic [13:0] waddr;
    logic [31:0] wword;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .dir_base_pfn(dir_base_pfn), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .resp_code(resp_code), .pa(pa)
  );

  function automatic logic [31:0] rd(input logic [13:0] a);
    int k = int'(a >> 2);
    if (mem.exists(k)) return mem[k];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder with programmable latency
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        mem_rdata <= rd(mem_addr);
        if (mem_we) mem[int'(mem_addr >> 2)] = mem_wdata;
        wcnt <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // monitor
  int nrd = 0, nwr = 0, ndone = 0;
  logic [13:0] ra0 = '0, ra1 = '0;
  logic done_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack) begin
        if (mem_we) nwr++;
        else begin
          if (nrd == 0) ra0 = mem_addr;
          if (nrd == 1) ra1 = mem_addr;
          nrd++;
        end
      end
      if (done && done_d) chk("R12 done width", 32'd2, 32'd1);
      if (done) begin
        exp_t e;
        ndone++;
        if (q.size() == 0) chk("R11 unexpected done", 32'd1, 32'd0);
        else begin
          e = q.pop_front();
          chk({e.tag, " R3/R5/R6/R7 code"}, 32'(resp_code), 32'(e.code));
          chk({e.tag, " R8 pa"}, 32'(pa), 32'(e.pa));
          chk({e.tag, " R10 reads"}, nrd, e.nrd);
          chk({e.tag, " R10 writes"}, nwr, e.nwr);
          chk({e.tag, " R2 dir addr"}, 32'(ra0), 32'(e.a0));
          if (e.nrd > 1) chk({e.tag, " R4 leaf addr"}, 32'(ra1), 32'(e.a1));
        end
        nrd = 0; nwr = 0;
      end
      done_d = done;
    end
  end

  function automatic exp_t predict(input logic [13:0] va, input logic wr, input string tag);
    exp_t e;
    logic [31:0] d, p, u;
    e.tag = tag; e.nwr = 0; e.pa = '0; e.a1 = '0; e.waddr = '0; e.wword = '0;
    e.a0 = {dir_base_pfn, va[13:10], 2'b00};
    d = rd(e.a0);
    if (!d[0]) begin e.code = 3'd1; e.nrd = 1; return e; end
    e.nrd = 2;
    e.a1 = {d[15:8], va[9:6], 2'b00};
    p = rd(e.a1);
    e.waddr = e.a1; e.wword = p;
    if (!p[0])           e.code = 3'd2;
    else if (!p[1])      e.code = 3'd3;
    else if (wr && !p[2]) e.code = 3'd4;
    else begin
      e.code = 3'd0;
      e.pa = {p[15:8], va[5:0]};
      u = p | 32'h8 | (wr ? 32'h10 : 32'h0);
      e.wword = u;
      if (u != p) e.nwr = 1;
    end
    return e;
  endfunction

  task automatic walk(input logic [3:0] pd, input logic [3:0] pt, input logic [5:0] off,
                      input logic wr, input int l, input string tag, input bit poke);
    exp_t e;
    logic [13:0] va = {pd, pt, off};
    while (busy) @(negedge clk);
    lat = l;
    e = predict(va, wr, tag);
    q.push_back(e);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      chk({tag, " R11 busy"}, 32'(busy), 32'd1);
      req_vaddr = 14'h0; req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk({tag, " R9 entry after walk"}, rd(e.waddr), e.wword);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // directory at frame 0x20 (byte 0x800); sub-tables at frames 0x30, 0x31
    mem[(14'h800 >> 2) + 0] = 32'h0000_3001;
    mem[(14'h800 >> 2) + 1] = 32'h0000_3100;
    mem[(14'h800 >> 2) + 2] = 32'h0000_3101;
    mem[(14'hC00 >> 2) + 0] = 32'h0000_4107;
    mem[(14'hC00 >> 2) + 1] = 32'h0000_4206;
    mem[(14'hC00 >> 2) + 2] = 32'h0000_4305;
    mem[(14'hC00 >> 2) + 3] = 32'h0000_4403;
    mem[(14'hC00 >> 2) + 4] = 32'h0000_451F;
    mem[(14'hC00 >> 2) + 5] = 32'h0000_460F;
    mem[(14'hC40 >> 2) + 15] = 32'hA500_7F07;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    walk(4'd0, 4'd0, 6'h15, 1'b0, 0, "R8 read ok sets A", 1'b0);
    walk(4'd0, 4'd0, 6'h2A, 1'b1, 1, "R9 write sets D", 1'b0);
    walk(4'd0, 4'd0, 6'h01, 1'b1, 2, "R10 no wb", 1'b0);
    walk(4'd1, 4'd3, 6'h00, 1'b0, 1, "R3 dir invalid", 1'b0);
    walk(4'd0, 4'd1, 6'h07, 1'b0, 0, "R5 leaf invalid", 1'b0);
    walk(4'd0, 4'd2, 6'h07, 1'b1, 3, "R6 not present", 1'b0);
    walk(4'd0, 4'd3, 6'h10, 1'b1, 0, "R7 protection", 1'b0);
    walk(4'd0, 4'd3, 6'h11, 1'b0, 1, "R9 read on read-only", 1'b0);
    walk(4'd0, 4'd4, 6'h3F, 1'b1, 0, "R10 flags set", 1'b0);
    walk(4'd0, 4'd5, 6'h20, 1'b1, 2, "R9 D only", 1'b0);
    walk(4'd2, 4'd15, 6'h3F, 1'b0, 3, "R11 poke ignored", 1'b1);
    repeat (4) @(negedge clk);
    chk("R11 done count", ndone, 11);
    chk("R11 queue empty", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule